// File: doc/BRIEF.md
# Refresh Request Generator with Backlog

This block produces the periodic refresh demand for a dynamic memory controller. A slow refresh timebase arrives as a one-cycle tick that has already been brought into the system clock domain. Every 64th tick yields one refresh request. The request goes into a saturating backlog count rather than straight to the sequencer. An access cycle, for example a long page-mode burst, can keep the memory busy across several request periods. The requests that arrive in that time are not lost. The sequencer runs them back to back once the bus is free.

The sequencer sees one level flag that stays high while any refresh is owed. It also sees the row address for the next refresh. Refresh cycles strobe only the row strobe and never the column strobe, so this one row address is all they need. The sequencer pulses a done input at the end of each refresh cycle. That pulse retires one owed refresh and advances the row address.

Top module: `refresh_backlog_gen`

## Requirements
- R1: While reset is low at a clock edge, the divider phase and the backlog clear. The row address loads all ones (1023 for 10 bits), and the pending flag reads 0 after that edge.
- R2: Cycles without a tick leave the divider phase unchanged. A request comes only on the 64th tick since reset or since the previous request.
- R3: The pending flag goes high in the clock cycle right after the edge that registers the 64th tick, and only after such an edge.
- R4: Each done pulse taken while pending is high retires one owed refresh. The pending flag drops only when the number of done pulses equals the number of logged requests.
- R5: The backlog holds at most 128. A request that arrives while 128 are already owed is dropped, so 128 done pulses clear the backlog after any larger burst.
- R6: When a request and a done pulse come on the same edge while the backlog is non-zero, the backlog count stays the same. This also holds at 128.
- R7: Each accepted done pulse raises the row address by exactly one. After all ones, it wraps to zero.
- R8: A done pulse while pending is low has no effect. The row address and the backlog stay unchanged.
- R9: Done pulses do not disturb the divider phase. The request period stays 64 ticks however refreshes are retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rclk_tick | input | 1 | One-cycle pulse per refresh timebase period, already synchronized |
| rfsh_done | input | 1 | One-cycle pulse from the sequencer at the end of a refresh cycle |
| rfsh_pend | output | 1 | High while at least one refresh is owed |
| rfsh_row | output | 10 | Row address for the next refresh cycle |

## Verification
The checker assumes that both the tick and the done input are plain synchronous pulses sampled once per clock edge. It also assumes the sequencer raises done only after it has seen pending, so a done pulse while pending is low counts as a stray event to ignore and not as a refresh served. The stimulus changes inputs only half a period away from the sampling edge. It issues each pulse for a single cycle, and it drives stray done pulses on purpose to exercise the ignore path. It also drives done on the very edge of a request to exercise the hold rule, both below and at the backlog ceiling.

// File: rtl/rfsh_pkg.sv
// Package: shared defaults and the backlog update code for the refresh
// request generator. Assumes nothing beyond being compiled first.
package rfsh_pkg;
    localparam int DEF_DIV_RATIO   = 64;
    localparam int DEF_BACKLOG_MAX = 128;
    localparam int DEF_ROW_W       = 10;

    // How the backlog count moves on one clock edge.
    typedef enum logic [1:0] {
        BL_HOLD = 2'd0,
        BL_INC  = 2'd1,
        BL_DEC  = 2'd2
    } bl_op_e;
endpackage

// File: rtl/rfsh_divider.sv
// Module: divides the synchronized refresh tick by DIV_RATIO.
// Emits a one-cycle request on the tick that completes a period.
// Assumes the tick is high for one system clock per timebase period.
module rfsh_divider #(
    parameter int DIV_RATIO = rfsh_pkg::DEF_DIV_RATIO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic req
);
    localparam int PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV_RATIO - 1);

    logic [PW-1:0] phase;
    logic          at_last;

    // Flag the final tick position of a period.
    always_comb begin
        at_last = (phase == LAST);
        req     = tick && at_last;
    end

    // Advance the phase only on ticks, wrapping at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick) begin
            phase <= at_last ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
// Module: saturating count of refreshes owed.
// Requests add one, accepted done pulses remove one, and both together hold.
// Assumes done is meaningful only while the count is non-zero.
module rfsh_backlog #(
    parameter int BACKLOG_MAX = rfsh_pkg::DEF_BACKLOG_MAX
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req,
    input  logic                               done,
    output logic [$clog2(BACKLOG_MAX+1)-1:0]   level,
    output logic                               accept,
    output logic                               pend
);
    import rfsh_pkg::*;

    localparam int CW = $clog2(BACKLOG_MAX + 1);
    localparam logic [CW-1:0] CAP = CW'(BACKLOG_MAX);

    bl_op_e op;

    // Decide the count update for this edge.
    always_comb begin
        pend   = (level != '0);
        accept = done && pend;
        if (req && accept)           op = BL_HOLD;
        else if (req && level < CAP) op = BL_INC;
        else if (accept)             op = BL_DEC;
        else                         op = BL_HOLD;
    end

    // Apply the chosen update to the backlog register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case (op)
                BL_INC:  level <= level + 1'b1;
                BL_DEC:  level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_row_ctr.sv
// Module: row address for refresh cycles. It starts at all ones and counts up
// by one per served refresh, wrapping naturally.
// Assumes adv is high for one clock per completed refresh.
module rfsh_row_ctr #(
    parameter int ROW_W = rfsh_pkg::DEF_ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    // Load all ones at reset, step on each served refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '1;
        end else if (adv) begin
            row <= row + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_backlog_gen.sv
// Module: top of the refresh request generator. It chains the tick divider
// into the backlog counter and steps the row counter on served refreshes.
// Assumes both inputs are single-cycle pulses synchronous to clk.
module refresh_backlog_gen #(
    parameter int DIV_RATIO   = rfsh_pkg::DEF_DIV_RATIO,
    parameter int BACKLOG_MAX = rfsh_pkg::DEF_BACKLOG_MAX,
    parameter int ROW_W       = rfsh_pkg::DEF_ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rclk_tick,
    input  logic             rfsh_done,
    output logic             rfsh_pend,
    output logic [ROW_W-1:0] rfsh_row
);
    localparam int CW = $clog2(BACKLOG_MAX + 1);

    logic          div_req;
    logic          bl_accept;
    logic [CW-1:0] bl_level;

    rfsh_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rclk_tick),
        .req   (div_req)
    );

    rfsh_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_bl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (div_req),
        .done   (rfsh_done),
        .level  (bl_level),
        .accept (bl_accept),
        .pend   (rfsh_pend)
    );

    rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bl_accept),
        .row   (rfsh_row)
    );
endmodule

// File: rtl/rfsh_chk.sv
// Module: property checker for refresh_backlog_gen, bound to the top module.
// Assumes single-cycle input pulses and a synchronous active-low reset.
module rfsh_chk #(
    parameter int BACKLOG_MAX = 128,
    parameter int ROW_W       = 10,
    parameter int CW          = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             done,
    input logic             accept,
    input logic [CW-1:0]    level,
    input logic             pend,
    input logic [ROW_W-1:0] row
);
    // R5
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(BACKLOG_MAX));

    // R3
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(req));

    // R4
    pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> ($past(done) && $past(level) == CW'(1)));

    // R6
    same_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && done && level != '0) |=> $stable(level));

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row) |-> (row == ROW_W'($past(row) + 1'b1) && $past(accept)));

    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pend) |=> ($stable(row) && $stable(level)));
endmodule

bind refresh_backlog_gen rfsh_chk #(
    .BACKLOG_MAX (BACKLOG_MAX),
    .ROW_W       (ROW_W),
    .CW          ($clog2(BACKLOG_MAX + 1))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (div_req),
    .done   (rfsh_done),
    .accept (bl_accept),
    .level  (bl_level),
    .pend   (rfsh_pend),
    .row    (rfsh_row)
);

// File: tb/sim_refresh_backlog_gen.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements and queues them; the monitor compares after each edge.
module sim_refresh_backlog_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rclk_tick = 1'b0;
    logic       rfsh_done = 1'b0;
    logic       rfsh_pend;
    logic [9:0] rfsh_row;

    typedef struct {
        logic       pend;
        logic [9:0] row;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // Reference state taken from the requirements
    int   m_phase = 0;
    int   m_bl = 0;
    int   m_row = 1023;

    always #10 clk = ~clk;   // 50 MHz

    refresh_backlog_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rclk_tick (rclk_tick),
        .rfsh_done (rfsh_done),
        .rfsh_pend (rfsh_pend),
        .rfsh_row  (rfsh_row)
    );

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input bit t, input bit d, input string tag);
        bit   rq;
        bit   acc;
        exp_t e;
        @(negedge clk);
        rclk_tick = t;
        rfsh_done = d;
        rq  = t && (m_phase == 63);
        acc = d && (m_bl != 0);
        if (t) m_phase = (m_phase == 63) ? 0 : m_phase + 1;
        if (rq && acc)             m_bl = m_bl;
        else if (rq && m_bl < 128) m_bl = m_bl + 1;
        else if (acc)              m_bl = m_bl - 1;
        if (acc) m_row = (m_row + 1) % 1024;
        @(posedge clk);
        e.pend = (m_bl != 0);
        e.row  = 10'(m_row);
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
    endtask

    // Monitor: compare queued expectations a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (rfsh_pend !== e.pend || rfsh_row !== e.row) begin
                    n_fail++;
                    $display("FAIL %s: pend=%0b row=%0d expected pend=%0b row=%0d",
                             e.tag, rfsh_pend, rfsh_row, e.pend, e.row);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        step(1'b0, 1'b0, "R1");

        // R2: 63 sparse ticks, gaps in between, no request yet
        for (int i = 0; i < 63; i++) begin
            step(1'b1, 1'b0, "R2");
            step(1'b0, 1'b0, "R2");
        end
        // R3: 64th tick raises pending on the next cycle
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, "R3");

        // R7: first served refresh wraps the row from 1023 to 0, R4 clears
        step(1'b0, 1'b1, "R7");
        step(1'b0, 1'b0, "R4");

        // R8: stray done while idle is ignored
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, "R8");

        // R4: three logged requests need three done pulses
        ticks(192, "R4");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, "R4");
        step(1'b0, 1'b0, "R4");

        // R9: done pulses between ticks keep the period at 64
        ticks(64, "R9");
        ticks(10, "R9");
        step(1'b0, 1'b1, "R9");
        ticks(53, "R9");
        step(1'b1, 1'b0, "R9");

        // R6: request and done on the same edge hold the count at 1
        ticks(63, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b0, 1'b0, "R6");

        // R5: 130 requests saturate at 128
        ticks(64 * 130, "R5");
        // R6: simultaneous request and done at the ceiling also hold
        ticks(63, "R6");
        step(1'b1, 1'b1, "R6");
        for (int i = 0; i < 127; i++) step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, "R8");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule